// File: doc/BRIEF.md
# Effective Address Sequencer with Cycle Costing

This block forms the effective address of a memory operand for an 8-bit processor. It covers zero-page, indexed, absolute and indirect modes, relative branches, indirect jumps, subroutine calls and subroutine returns. On `start` it latches the mode, the index registers, the stack pointer, the address of the first operand byte and two flags: store and branch taken. It then fetches the operand and pointer bytes it needs through a synchronous read port, one byte per cycle. The read data appears on `mem_data` in the cycle after the request.

When the walk is complete, the block raises `done` for one cycle. In that cycle `eff_addr` holds the resolved address and `cycles` holds the instruction's cycle count. The count includes the page-crossing penalty for indexed reads and the taken and crossing penalties for branches. For a call, `link_addr` holds the return address that would be pushed.

Top module: `addr_unit`

## Requirements
- R1: Mode 0 (zero page) returns the operand byte as the address. Modes 1 (zero page plus X) and 2 (zero page plus Y) add the index modulo 256, so the upper address byte is always 0x00.
- R2: Mode 6 (pre-indexed indirect) adds X modulo 256 to the operand to get a page-0 pointer. It reads the low byte there and the high byte at the next page-0 location, wrapping from 0xFF to 0x00, and returns that 16-bit word.
- R3: Mode 7 (post-indexed indirect) reads a little-endian pointer from the page-0 location named by the operand, then adds Y as a 16-bit sum.
- R4: A read (`is_store`=0) in mode 4 (absolute plus X) or mode 5 (absolute plus Y) costs 4 cycles, or 5 when the upper byte of the indexed address differs from the base. A read in mode 7 costs 5 cycles, or 6 on such a crossing.
- R5: A store (`is_store`=1) in modes 4 or 5 costs 5 cycles and a store in mode 7 costs 6 cycles, whether or not a page is crossed.
- R6: Mode 8 (branch) reads a signed offset at `pc_in`. The target is `pc_in`+1 plus the offset. When `taken`=1 the block returns the target and costs 3 cycles, or 4 if the target's upper byte differs from that of `pc_in`+1. When `taken`=0 it returns `pc_in`+1 and costs 2 cycles.
- R7: Mode 9 (indirect jump) reads a 16-bit pointer at `pc_in` and then reads the little-endian word at that pointer and at the pointer plus one, using full 16-bit carry. It returns that word and costs 5 cycles.
- R8: Mode 10 (call) returns the absolute operand, reports `link_addr` = `pc_in`+1 (the last operand byte), and costs 6 cycles. Mode 11 (return) reads the low byte at 0x0100+(`sp_in`+1 mod 256) and the high byte at 0x0100+(`sp_in`+2 mod 256). It returns that word plus one and costs 6 cycles.
- R9: Mode 0 costs 3 cycles, modes 1 and 2 cost 4, mode 3 (absolute, little-endian operand at `pc_in` and `pc_in`+1) costs 4, and mode 6 costs 6.
- R10: `done` is high for exactly one cycle per accepted request, with `eff_addr` and `cycles` valid in that cycle. `start` is ignored while a request is in progress. A `start` in the `done` cycle is accepted.
- R11: After reset `done` and `mem_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a request; sampled only when idle |
| mode | input | 4 | Addressing mode code (see requirements) |
| is_store | input | 1 | 1 for a write access |
| taken | input | 1 | Branch condition result |
| idx_x | input | 8 | X index |
| idx_y | input | 8 | Y index |
| sp_in | input | 8 | Stack pointer |
| pc_in | input | 16 | Address of the first operand byte |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_data | input | 8 | Read data, one cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 16 | Resolved address |
| link_addr | output | 16 | Return address for a call |
| cycles | output | 3 | Instruction cycle count |

## Verification
The completion of one request and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start` for a new mode while `done` of the previous request is high. It judges the result by checking that the first result is intact and that the second request returns its own address and cost. The opposite case, a `start` raised during a walk, is also provoked. It is judged by confirming that the result belongs to the first request and that no second `done` follows.

// File: rtl/addr_unit.sv
module addr_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic        is_store,
  input  logic        taken,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic [7:0]  sp_in,
  input  logic [15:0] pc_in,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_data,
  output logic        done,
  output logic [15:0] eff_addr,
  output logic [15:0] link_addr,
  output logic [2:0]  cycles
);
  localparam logic [3:0] M_ZP = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_ABS = 4'd3,
                         M_ABSX = 4'd4, M_ABSY = 4'd5, M_INDX = 4'd6, M_INDY = 4'd7,
                         M_REL = 4'd8, M_JMPI = 4'd9, M_CALL = 4'd10, M_RET = 4'd11;

  typedef enum logic [2:0] {S_IDLE, S_A, S_B, S_C, S_D, S_E} st_t;
  st_t st;

  logic [3:0]  md;
  logic        wr_q, tk_q;
  logic [7:0]  x_q, y_q, sp_q, lo_q, zp_q;
  logic [15:0] pc_q, ptr_q;

  logic        fin;
  logic [15:0] res;
  logic [2:0]  cyc;

  wire [15:0] word   = {mem_data, lo_q};
  wire [7:0]  ix     = (md == M_ABSX) ? x_q : y_q;
  wire [15:0] isum   = word + {8'h00, ix};
  wire        icross = isum[15:8] != mem_data;
  wire [15:0] nxt    = pc_q + 16'd1;
  wire [15:0] tgt    = nxt + {{8{mem_data[7]}}, mem_data};
  wire        bcross = tgt[15:8] != nxt[15:8];
  wire        one_byte = (md == M_ZP) || (md == M_ZPX) || (md == M_ZPY) || (md == M_REL);
  wire        zp_ind   = (md == M_INDX) || (md == M_INDY);

  always_comb begin
    mem_rd = 1'b0;
    mem_addr = 16'h0000;
    fin = 1'b0;
    res = 16'h0000;
    cyc = 3'd0;
    case (st)
      S_A: begin
        mem_rd = 1'b1;
        mem_addr = (md == M_RET) ? {8'h01, sp_q + 8'd1} : pc_q;
      end
      S_B: begin
        if (one_byte) begin
          fin = 1'b1;
          case (md)
            M_ZPX:   begin res = {8'h00, mem_data + x_q}; cyc = 3'd4; end
            M_ZPY:   begin res = {8'h00, mem_data + y_q}; cyc = 3'd4; end
            M_REL:   begin
              res = tk_q ? tgt : nxt;
              cyc = !tk_q ? 3'd2 : (bcross ? 3'd4 : 3'd3);
            end
            default: begin res = {8'h00, mem_data}; cyc = 3'd3; end
          endcase
        end else begin
          mem_rd = 1'b1;
          if (md == M_INDX)      mem_addr = {8'h00, mem_data + x_q};
          else if (md == M_INDY) mem_addr = {8'h00, mem_data};
          else if (md == M_RET)  mem_addr = {8'h01, sp_q + 8'd2};
          else                   mem_addr = pc_q + 16'd1;
        end
      end
      S_C: begin
        case (md)
          M_INDX, M_INDY: begin mem_rd = 1'b1; mem_addr = {8'h00, zp_q + 8'd1}; end
          M_JMPI:         begin mem_rd = 1'b1; mem_addr = word; end
          M_ABSX, M_ABSY: begin
            fin = 1'b1; res = isum;
            cyc = wr_q ? 3'd5 : (icross ? 3'd5 : 3'd4);
          end
          M_CALL:  begin fin = 1'b1; res = word; cyc = 3'd6; end
          M_RET:   begin fin = 1'b1; res = word + 16'd1; cyc = 3'd6; end
          default: begin fin = 1'b1; res = word; cyc = 3'd4; end
        endcase
      end
      S_D: begin
        if (md == M_JMPI) begin
          mem_rd = 1'b1; mem_addr = ptr_q + 16'd1;
        end else if (md == M_INDY) begin
          fin = 1'b1; res = isum;
          cyc = wr_q ? 3'd6 : (icross ? 3'd6 : 3'd5);
        end else begin
          fin = 1'b1; res = word; cyc = 3'd6;
        end
      end
      S_E: begin fin = 1'b1; res = word; cyc = 3'd5; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      md <= M_ZP;
      {wr_q, tk_q} <= 2'b00;
      {x_q, y_q, sp_q, lo_q, zp_q} <= '0;
      pc_q <= 16'h0000;
      ptr_q <= 16'h0000;
      done <= 1'b0;
      eff_addr <= 16'h0000;
      link_addr <= 16'h0000;
      cycles <= 3'd0;
    end else begin
      done <= fin;
      if (fin) begin
        eff_addr <= res;
        cycles <= cyc;
        link_addr <= pc_q + 16'd1;
      end
      case (st)
        S_IDLE: if (start) begin
          st <= S_A;
          md <= mode; wr_q <= is_store; tk_q <= taken;
          x_q <= idx_x; y_q <= idx_y; sp_q <= sp_in; pc_q <= pc_in;
        end
        S_A: st <= S_B;
        S_B: begin
          lo_q <= mem_data;
          zp_q <= (md == M_INDX) ? mem_data + x_q : mem_data;
          st <= fin ? S_IDLE : S_C;
        end
        S_C: begin
          lo_q <= mem_data;
          ptr_q <= word;
          st <= fin ? S_IDLE : S_D;
        end
        S_D: begin
          lo_q <= mem_data;
          st <= fin ? S_IDLE : S_E;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_zp_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && (md == M_ZPX || md == M_ZPY) |-> eff_addr[15:8] == 8'h00);
  assert_ptr_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && zp_ind && (st == S_B || st == S_C) |-> mem_addr[15:8] == 8'h00);
  assert_read_cost_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr_q && (md == M_ABSX || md == M_ABSY) |-> (cycles == 3'd4 || cycles == 3'd5));
  assert_store_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && wr_q && (md == M_ABSX || md == M_ABSY) |-> cycles == 3'd5);
  assert_branch_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && md == M_REL |-> (cycles >= 3'd2 && cycles <= 3'd4));
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/addr_unit_test.sv
module addr_unit_test;
  logic clk = 0, rst_n = 0, start = 0, is_store = 0, taken = 0;
  logic [3:0] mode = 0;
  logic [7:0] idx_x = 0, idx_y = 0, sp_in = 0, mem_data;
  logic [15:0] pc_in = 0, mem_addr, eff_addr, link_addr;
  logic mem_rd, done;
  logic [2:0] cycles;
  logic [7:0] mem [int];
  int tests = 0, fails = 0, ticks = 0;

  always #4 clk = ~clk;

  addr_unit uut (.clk, .rst_n, .start, .mode, .is_store, .taken, .idx_x, .idx_y,
                 .sp_in, .pc_in, .mem_rd, .mem_addr, .mem_data, .done, .eff_addr,
                 .link_addr, .cycles);

  always @(posedge clk) if (mem_rd) mem_data <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hEE;

  always @(posedge clk) begin
    ticks++;
    if (ticks > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] m, logic st, logic tk, logic [7:0] x, logic [7:0] y,
                       logic [7:0] sp, logic [15:0] pc);
    @(negedge clk);
    mode = m; is_store = st; taken = tk; idx_x = x; idx_y = y; sp_in = sp; pc_in = pc;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 20 && !done; n++) @(negedge clk);
  endtask

  task automatic run(string tag, logic [3:0] m, logic st, logic tk, logic [7:0] x,
                     logic [7:0] y, logic [7:0] sp, logic [15:0] pc,
                     logic [15:0] ea, logic [2:0] cy);
    issue(m, st, tk, x, y, sp, pc);
    wait_done();
    chk({tag, " done R10"}, {15'd0, done}, 16'd1);
    chk({tag, " addr"}, eff_addr, ea);
    chk({tag, " cycles"}, {13'd0, cycles}, {13'd0, cy});
    @(negedge clk);
    chk({tag, " pulse R10"}, {15'd0, done}, 16'd0);
  endtask

  task automatic t_reset();
    chk("R11 done", {15'd0, done}, 16'd0);
    chk("R11 mem_rd", {15'd0, mem_rd}, 16'd0);
  endtask

  task automatic t_zero_page();
    mem[32'h0200] = 8'h34;
    run("R9 zp", 4'd0, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0200, 16'h0034, 3'd3);
    mem[32'h0201] = 8'hF0;
    run("R1 zpx wrap", 4'd1, 0, 0, 8'h20, 8'h00, 8'h00, 16'h0201, 16'h0010, 3'd4);
    mem[32'h0202] = 8'h80;
    run("R1 zpy", 4'd2, 1, 0, 8'h00, 8'h7F, 8'h00, 16'h0202, 16'h00FF, 3'd4);
  endtask

  task automatic t_absolute();
    mem[32'h0300] = 8'h78; mem[32'h0301] = 8'h56;
    run("R9 abs", 4'd3, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0300, 16'h5678, 3'd4);
    run("R4 absx same page", 4'd4, 0, 0, 8'h01, 8'h00, 8'h00, 16'h0300, 16'h5679, 3'd4);
    run("R4 absx cross", 4'd4, 0, 0, 8'h90, 8'h00, 8'h00, 16'h0300, 16'h5708, 3'd5);
    run("R4 absy cross", 4'd5, 0, 0, 8'h00, 8'hA0, 8'h00, 16'h0300, 16'h5718, 3'd5);
    run("R5 absy store cross", 4'd5, 1, 0, 8'h00, 8'hA0, 8'h00, 16'h0300, 16'h5718, 3'd5);
    run("R5 absx store same", 4'd4, 1, 0, 8'h02, 8'h00, 8'h00, 16'h0300, 16'h567A, 3'd5);
  endtask

  task automatic t_indirect();
    mem[32'h0220] = 8'hFE; mem[32'h00FF] = 8'h21; mem[32'h0000] = 8'h43;
    run("R2 indx wrap", 4'd6, 0, 0, 8'h01, 8'h00, 8'h00, 16'h0220, 16'h4321, 3'd6);
    mem[32'h0221] = 8'h40; mem[32'h0040] = 8'hF0; mem[32'h0041] = 8'h12;
    run("R3 indy same", 4'd7, 0, 0, 8'h00, 8'h05, 8'h00, 16'h0221, 16'h12F5, 3'd5);
    run("R4 indy cross", 4'd7, 0, 0, 8'h00, 8'h20, 8'h00, 16'h0221, 16'h1310, 3'd6);
    run("R5 indy store", 4'd7, 1, 0, 8'h00, 8'h05, 8'h00, 16'h0221, 16'h12F5, 3'd6);
  endtask

  task automatic t_branch();
    mem[32'h0210] = 8'h05;
    run("R6 taken", 4'd8, 0, 1, 8'h00, 8'h00, 8'h00, 16'h0210, 16'h0216, 3'd3);
    run("R6 not taken", 4'd8, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0210, 16'h0211, 3'd2);
    mem[32'h0400] = 8'hF0;
    run("R6 back cross", 4'd8, 0, 1, 8'h00, 8'h00, 8'h00, 16'h0400, 16'h03F1, 3'd4);
  endtask

  task automatic t_jumps();
    mem[32'h0500] = 8'hFF; mem[32'h0501] = 8'h30; mem[32'h30FF] = 8'h11; mem[32'h3100] = 8'h22;
    run("R7 jmp ind", 4'd9, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0500, 16'h2211, 3'd5);
    mem[32'h0600] = 8'h00; mem[32'h0601] = 8'h80;
    issue(4'd10, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0600);
    wait_done();
    chk("R8 call addr", eff_addr, 16'h8000);
    chk("R8 call link", link_addr, 16'h0601);
    chk("R8 call cycles", {13'd0, cycles}, 16'd6);
    mem[32'h01FF] = 8'h02; mem[32'h0100] = 8'h06;
    run("R8 return", 4'd11, 0, 0, 8'h00, 8'h00, 8'hFE, 16'h0700, 16'h0603, 3'd6);
  endtask

  task automatic t_busy_start();
    int extra = 0;
    @(negedge clk);
    mode = 4'd0; pc_in = 16'h0200; start = 1;
    @(negedge clk);
    mode = 4'd3; pc_in = 16'h0300;
    @(negedge clk);
    start = 0;
    wait_done();
    chk("R10 busy start ignored", eff_addr, 16'h0034);
    for (int n = 0; n < 8; n++) begin @(negedge clk); if (done) extra++; end
    chk("R10 no second done", 16'(extra), 16'd0);
  endtask

  task automatic t_back_to_back();
    issue(4'd0, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0200);
    wait_done();
    chk("R10 first of pair", eff_addr, 16'h0034);
    mode = 4'd3; pc_in = 16'h0300; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    chk("R10 second of pair", eff_addr, 16'h5678);
    chk("R10 second cycles", {13'd0, cycles}, 16'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_zero_page();
    t_absolute();
    t_indirect();
    t_branch();
    t_jumps();
    t_busy_start();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule